// File: doc/BRIEF.md
# Memory Scrambling Key Controller

This block owns the scrambling key and nonce of an on-chip memory and decides whether memory requests may reach that memory. Software talks to it through a small word-addressed register file with a 32-bit data path. There are four registers: a read-only status word, a write-1-to-clear lock, a write-only control word and a read-only error-address word. When software asks for a key renewal, the block raises a request to a key provider and holds that request until the provider acknowledges. It then loads the delivered key, nonce and seed-valid flag.

A memory request passes the gate only when a valid key is loaded and no escalation has been seen. A blocked request is answered with a stall and is not forwarded. Parity errors reported by the memory set a flag that only a reset clears. While that flag is set, a fatal alert is held high. The byte address of the latest faulty access is kept for software. An escalation input moves the block into a terminal state: the key and nonce return to their defaults and all traffic is refused until reset.

The key provider runs on the same clock as this block.

Top module: `mem_key_ctrl`

## Requirements
- R1: After reset the status word reads 0, the lock word reads 1, `key_o`/`nonce_o` hold the default values, and `key_req_o` and `alert_o` are low.
- R2: A write of bit 0 = 1 to the control word (word 2) while unlocked, idle and not escalated clears status bit 2 (key valid) and bit 3 (seed valid) and raises `key_req_o` from the next cycle. `key_req_o` then stays high until `key_ack_i`. A control write with bit 0 = 0 starts nothing.
- R3: In a cycle where `key_req_o` and `key_ack_i` are both high, `key_i`, `nonce_i` and `seed_valid_i` are captured. From the next cycle `key_req_o` is low, status bit 2 is 1 and status bit 3 equals the captured seed flag.
- R4: A renewal write made while a request is pending is ignored: after the acknowledgement no further request is raised.
- R5: `mem_req_o` follows `mem_req_i` only while the key is valid and the block is not escalated. Otherwise `mem_req_o` is 0 and `mem_stall_o` equals `mem_req_i`.
- R6: `par_err_i` sets status bit 0 from the next cycle. The bit stays set until reset, and `alert_o` is high for as long as it is set.
- R7: The error-address word (word 3) holds `par_addr_i` from the most recent cycle in which `par_err_i` was high.
- R8: The lock word (word 1) resets to 1 and reads back in bit 0. Writing bit 0 = 1 clears it, and writing 0 leaves it unchanged. Once it is cleared, control writes start no request.
- R9: `escalate_i` sets status bit 1 (escalated) from the next cycle and returns `key_o`/`nonce_o` to their defaults. It clears key valid, and the state persists after `escalate_i` falls: renewal writes are ignored and memory requests stay blocked.
- R10: An acknowledgement for a request that was pending when escalation arrived still ends the request. Its key data are discarded, so key valid stays 0 and `key_o` keeps its default.
- R11: Writes to the status word (word 0) and the error-address word (word 3) change nothing that can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe, single cycle |
| reg_addr_i | input | 2 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, same cycle |
| key_req_o | output | 1 | Key request to the provider |
| key_ack_i | input | 1 | Key provider acknowledge |
| key_i | input | 128 | Key from the provider |
| nonce_i | input | 64 | Nonce from the provider |
| seed_valid_i | input | 1 | Provider flag: key derived from a valid seed |
| key_o | output | 128 | Current scrambling key |
| nonce_o | output | 64 | Current scrambling nonce |
| escalate_i | input | 1 | Escalation request |
| mem_req_i | input | 1 | Incoming memory request |
| mem_addr_i | input | 32 | Incoming memory byte address |
| mem_req_o | output | 1 | Request forwarded to the memory |
| mem_addr_o | output | 32 | Forwarded address, zero while blocked |
| mem_stall_o | output | 1 | Stall response for a blocked request |
| par_err_i | input | 1 | Parity error from the memory |
| par_addr_i | input | 32 | Byte address of the access that failed parity |
| alert_o | output | 1 | Fatal parity alert |

## Verification
The gate and the renewal handshake are exercised in four situations:
- before any key is loaded;
- while a request is pending with no acknowledgement and a second renewal write is made;
- after an acknowledgement with the seed flag at 1 and again at 0;
- with escalation arriving while a request is pending.

Together these separate the key-valid path from the pending path and the escalated path. They also show whether a late acknowledgement is wrongly accepted. Two parity errors at different addresses show that the address is overwritten while the error flag stays set. Lock writes of 0 and then 1, followed by a renewal write, show whether the lock really gates the control word.

// File: rtl/mkc_pkg.sv
package mkc_pkg;

    // Register word indices
    localparam int unsigned OFS_STATUS  = 0;
    localparam int unsigned OFS_LOCK    = 1;
    localparam int unsigned OFS_CTRL    = 2;
    localparam int unsigned OFS_ERRADDR = 3;

    // Status word layout, bit 0 upward: err, esc, valid, seed
    typedef struct packed {
        logic seed;
        logic valid;
        logic esc;
        logic err;
    } status_t;

    localparam int unsigned STATUS_W = $bits(status_t);

endpackage

// File: rtl/mkc_regs.sv
module mkc_regs
    import mkc_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  status_t       status_i,
    input  logic [DW-1:0] err_addr_i,
    output logic [DW-1:0] rdata_o,
    output logic          renew_o,
    output logic          lock_o
);

    localparam logic [AW-1:0] A_STATUS  = AW'(OFS_STATUS);
    localparam logic [AW-1:0] A_LOCK    = AW'(OFS_LOCK);
    localparam logic [AW-1:0] A_CTRL    = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_ERRADDR = AW'(OFS_ERRADDR);

    typedef struct packed {
        logic lock;
    } st_t;

    st_t st_d, st_q;

    logic unused_wdata;
    assign unused_wdata = ^wdata_i[DW-1:1];

    always_comb begin
        st_d    = st_q;
        renew_o = 1'b0;
        if (we_i && addr_i == A_LOCK && wdata_i[0]) begin
            st_d.lock = 1'b0;
        end
        if (we_i && addr_i == A_CTRL && wdata_i[0] && st_q.lock) begin
            renew_o = 1'b1;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_STATUS:  rdata_o = DW'(status_i);
            A_LOCK:    rdata_o = DW'(st_q.lock);
            A_ERRADDR: rdata_o = err_addr_i;
            default:   rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{lock: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o = st_q.lock;

endmodule

// File: rtl/mkc_keymgr.sv
module mkc_keymgr #(
    parameter int unsigned          KEY_W     = 128,
    parameter int unsigned          NONCE_W   = 64,
    parameter logic [KEY_W-1:0]     DEF_KEY   = '0,
    parameter logic [NONCE_W-1:0]   DEF_NONCE = '0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               renew_i,
    input  logic               esc_i,
    input  logic               ack_i,
    input  logic [KEY_W-1:0]   key_i,
    input  logic [NONCE_W-1:0] nonce_i,
    input  logic               seed_i,
    output logic               req_o,
    output logic               valid_o,
    output logic               seed_o,
    output logic               esc_o,
    output logic [KEY_W-1:0]   key_o,
    output logic [NONCE_W-1:0] nonce_o
);

    typedef struct packed {
        logic               pend;
        logic               valid;
        logic               seed;
        logic               esc;
        logic [KEY_W-1:0]   key;
        logic [NONCE_W-1:0] nonce;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Acknowledge closes the handshake; data kept only when not escalated
        if (st_q.pend && ack_i) begin
            st_d.pend = 1'b0;
            if (!st_q.esc && !esc_i) begin
                st_d.valid = 1'b1;
                st_d.seed  = seed_i;
                st_d.key   = key_i;
                st_d.nonce = nonce_i;
            end
        end
        // New renewal only from idle and non-escalated state
        if (renew_i && !st_q.pend && !st_q.esc) begin
            st_d.pend  = 1'b1;
            st_d.valid = 1'b0;
            st_d.seed  = 1'b0;
        end
        // Terminal escalation restores defaults on every cycle
        if (esc_i || st_q.esc) begin
            st_d.esc   = 1'b1;
            st_d.valid = 1'b0;
            st_d.seed  = 1'b0;
            st_d.key   = DEF_KEY;
            st_d.nonce = DEF_NONCE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{pend: 1'b0, valid: 1'b0, seed: 1'b0, esc: 1'b0,
                      key: DEF_KEY, nonce: DEF_NONCE};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o   = st_q.pend;
    assign valid_o = st_q.valid;
    assign seed_o  = st_q.seed;
    assign esc_o   = st_q.esc;
    assign key_o   = st_q.key;
    assign nonce_o = st_q.nonce;

endmodule

// File: rtl/mkc_errlog.sv
module mkc_errlog #(
    parameter int unsigned DW     = 32,
    parameter int unsigned MEM_AW = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              par_err_i,
    input  logic [MEM_AW-1:0] par_addr_i,
    output logic              err_o,
    output logic [DW-1:0]     addr_o,
    output logic              alert_o
);

    typedef struct packed {
        logic          err;
        logic [DW-1:0] addr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (par_err_i) begin
            st_d.err  = 1'b1;
            st_d.addr = DW'(par_addr_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o   = st_q.err;
    assign addr_o  = st_q.addr;
    assign alert_o = st_q.err;

endmodule

// File: rtl/mkc_gate.sv
module mkc_gate #(
    parameter int unsigned MEM_AW = 32
) (
    input  logic              key_valid_i,
    input  logic              esc_i,
    input  logic              req_i,
    input  logic [MEM_AW-1:0] addr_i,
    output logic              req_o,
    output logic [MEM_AW-1:0] addr_o,
    output logic              stall_o
);

    logic open_d;

    always_comb begin
        open_d  = key_valid_i && !esc_i;
        req_o   = req_i && open_d;
        stall_o = req_i && !open_d;
        addr_o  = open_d ? addr_i : '0;
    end

endmodule

// File: rtl/mem_key_ctrl.sv
module mem_key_ctrl
    import mkc_pkg::*;
#(
    parameter int unsigned        DW        = 32,
    parameter int unsigned        AW        = 2,
    parameter int unsigned        MEM_AW    = 32,
    parameter int unsigned        KEY_W     = 128,
    parameter int unsigned        NONCE_W   = 64,
    parameter logic [KEY_W-1:0]   DEF_KEY   = {(KEY_W/8){8'hA7}},
    parameter logic [NONCE_W-1:0] DEF_NONCE = {(NONCE_W/8){8'h3D}}
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               reg_we_i,
    input  logic [AW-1:0]      reg_addr_i,
    input  logic [DW-1:0]      reg_wdata_i,
    output logic [DW-1:0]      reg_rdata_o,
    output logic               key_req_o,
    input  logic               key_ack_i,
    input  logic [KEY_W-1:0]   key_i,
    input  logic [NONCE_W-1:0] nonce_i,
    input  logic               seed_valid_i,
    output logic [KEY_W-1:0]   key_o,
    output logic [NONCE_W-1:0] nonce_o,
    input  logic               escalate_i,
    input  logic               mem_req_i,
    input  logic [MEM_AW-1:0]  mem_addr_i,
    output logic               mem_req_o,
    output logic [MEM_AW-1:0]  mem_addr_o,
    output logic               mem_stall_o,
    input  logic               par_err_i,
    input  logic [MEM_AW-1:0]  par_addr_i,
    output logic               alert_o
);

    logic          renew;
    logic          lock_on;
    logic          key_valid;
    logic          seed_flag;
    logic          escalated;
    logic          err_flag;
    logic [DW-1:0] err_addr;
    status_t       status;

    assign status = '{seed: seed_flag, valid: key_valid, esc: escalated, err: err_flag};

    mkc_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (reg_we_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .status_i   (status),
        .err_addr_i (err_addr),
        .rdata_o    (reg_rdata_o),
        .renew_o    (renew),
        .lock_o     (lock_on)
    );

    mkc_keymgr #(
        .KEY_W(KEY_W), .NONCE_W(NONCE_W), .DEF_KEY(DEF_KEY), .DEF_NONCE(DEF_NONCE)
    ) u_keymgr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .renew_i (renew),
        .esc_i   (escalate_i),
        .ack_i   (key_ack_i),
        .key_i   (key_i),
        .nonce_i (nonce_i),
        .seed_i  (seed_valid_i),
        .req_o   (key_req_o),
        .valid_o (key_valid),
        .seed_o  (seed_flag),
        .esc_o   (escalated),
        .key_o   (key_o),
        .nonce_o (nonce_o)
    );

    mkc_errlog #(.DW(DW), .MEM_AW(MEM_AW)) u_errlog (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .par_err_i  (par_err_i),
        .par_addr_i (par_addr_i),
        .err_o      (err_flag),
        .addr_o     (err_addr),
        .alert_o    (alert_o)
    );

    mkc_gate #(.MEM_AW(MEM_AW)) u_gate (
        .key_valid_i (key_valid),
        .esc_i       (escalated),
        .req_i       (mem_req_i),
        .addr_i      (mem_addr_i),
        .req_o       (mem_req_o),
        .addr_o      (mem_addr_o),
        .stall_o     (mem_stall_o)
    );

endmodule

// File: rtl/mkc_chk.sv
module mkc_chk #(
    parameter int unsigned      KEY_W   = 128,
    parameter logic [KEY_W-1:0] DEF_KEY = '0
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             key_req_o,
    input logic             key_ack_i,
    input logic             alert_o,
    input logic             mem_req_o,
    input logic             key_valid,
    input logic             escalated,
    input logic             lock_on,
    input logic [KEY_W-1:0] key_o
);

    // R2
    req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        key_req_o && !key_ack_i |=> key_req_o);

    // R3
    req_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        key_req_o && key_ack_i |=> !key_req_o);

    // R5
    gate_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |-> key_valid && !escalated);

    // R6
    alert_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alert_o |=> alert_o);

    // R8
    lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_on |=> !lock_on);

    // R9
    esc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        escalated |=> escalated && key_o == DEF_KEY);

    // R10
    esc_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        escalated && key_ack_i |=> !key_valid);

endmodule

bind mem_key_ctrl mkc_chk #(.KEY_W(KEY_W), .DEF_KEY(DEF_KEY)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_req_o (key_req_o),
    .key_ack_i (key_ack_i),
    .alert_o   (alert_o),
    .mem_req_o (mem_req_o),
    .key_valid (key_valid),
    .escalated (escalated),
    .lock_on   (lock_on),
    .key_o     (key_o)
);

// File: tb/mem_key_ctrl_tb.sv
module mem_key_ctrl_tb;

    localparam logic [127:0] DEFK = {16{8'hA7}};
    localparam logic [63:0]  DEFN = {8{8'h3D}};
    localparam logic [127:0] K1 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    localparam logic [63:0]  N1 = 64'h1111_2222_3333_4444;
    localparam logic [127:0] K2 = 128'hDEAD_BEEF_0000_FFFF_1234_5678_9ABC_DEF0;
    localparam logic [63:0]  N2 = 64'h5555_6666_7777_8888;
    localparam logic [127:0] K3 = 128'h7777_0000_7777_0000_7777_0000_7777_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         key_req;
    logic         key_ack = 1'b0;
    logic [127:0] key_in = '0;
    logic [63:0]  nonce_in = '0;
    logic         seed_in = 1'b0;
    logic [127:0] key_out;
    logic [63:0]  nonce_out;
    logic         esc = 1'b0;
    logic         mreq = 1'b0;
    logic [31:0]  maddr = 32'h0000_0040;
    logic         mreq_o;
    logic [31:0]  maddr_o;
    logic         mstall;
    logic         perr = 1'b0;
    logic [31:0]  paddr = '0;
    logic         alert;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mem_key_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .key_req_o(key_req), .key_ack_i(key_ack), .key_i(key_in), .nonce_i(nonce_in),
        .seed_valid_i(seed_in), .key_o(key_out), .nonce_o(nonce_out), .escalate_i(esc),
        .mem_req_i(mreq), .mem_addr_i(maddr), .mem_req_o(mreq_o), .mem_addr_o(maddr_o),
        .mem_stall_o(mstall), .par_err_i(perr), .par_addr_i(paddr), .alert_o(alert)
    );

    // Scoreboard items: kind selects the observed output
    typedef struct {
        int           kind;
        logic [127:0] exp;
        string        tag;
    } item_t;

    item_t sb[$];

    function automatic logic [127:0] observe(int kind);
        case (kind)
            0: return 128'(reg_rdata);
            1: return 128'(key_req);
            2: return 128'(alert);
            3: return 128'(mreq_o);
            4: return 128'(mstall);
            5: return key_out;
            6: return 128'(nonce_out);
            default: return 128'(maddr_o);
        endcase
    endfunction

    // Monitor: samples 4 ns after each falling edge, before the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #4;
            while (sb.size() > 0) begin
                item_t it;
                logic [127:0] act;
                it = sb.pop_front();
                act = observe(it.kind);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_port(int kind, logic [127:0] e, string tag);
        sb.push_back('{kind: kind, exp: e, tag: tag});
    endtask

    task automatic expect_reg(logic [1:0] a, logic [31:0] e, string tag);
        reg_addr = a;
        sb.push_back('{kind: 0, exp: 128'(e), tag: tag});
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic ack(logic [127:0] k, logic [63:0] n, logic s);
        @(negedge clk);
        key_ack = 1'b1; key_in = k; nonce_in = n; seed_in = s;
        @(negedge clk);
        key_ack = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1 reset state; R5 gate closed without a key
        mreq = 1'b1;
        expect_port(1, 0, "R1 key_req after reset");
        expect_port(2, 0, "R1 alert after reset");
        expect_port(5, DEFK, "R1 default key");
        expect_port(6, 128'(DEFN), "R1 default nonce");
        expect_port(3, 0, "R5 mem_req blocked before key");
        expect_port(4, 1, "R5 stall before key");
        expect_reg(2'd0, 32'h0, "R1 status after reset");
        expect_reg(2'd1, 32'h1, "R1 lock after reset");

        // R2 control write with bit0=0 starts nothing
        wr(2'd2, 32'h0);
        expect_port(1, 0, "R2 no request on zero write");

        // R2 renewal raises request, held without ack
        wr(2'd2, 32'h1);
        expect_port(1, 1, "R2 request raised");
        repeat (3) @(negedge clk);
        expect_port(1, 1, "R2 request held without ack");

        // R4 second renewal while pending
        wr(2'd2, 32'h1);
        ack(K1, N1, 1'b1);
        // R3 capture
        expect_port(1, 0, "R3 request dropped after ack");
        expect_port(5, K1, "R3 key loaded");
        expect_port(6, 128'(N1), "R3 nonce loaded");
        expect_reg(2'd0, 32'hC, "R3 status valid+seed");
        expect_port(1, 0, "R4 no second request");
        @(negedge clk);
        expect_port(1, 0, "R4 still no request");

        // R5 open gate
        mreq = 1'b1; maddr = 32'h0000_0AB0;
        @(negedge clk);
        expect_port(3, 1, "R5 mem_req passes");
        expect_port(4, 0, "R5 no stall");
        expect_port(7, 128'(32'h0000_0AB0), "R5 address forwarded");
        @(negedge clk);
        mreq = 1'b0;
        @(negedge clk);
        expect_port(3, 0, "R5 idle follows input");

        // R2 renewal clears valid, blocks traffic; R3 seed=0
        wr(2'd2, 32'h1);
        mreq = 1'b1;
        expect_reg(2'd0, 32'h0, "R2 valid and seed cleared");
        expect_port(3, 0, "R5 blocked during renewal");
        expect_port(4, 1, "R5 stall during renewal");
        ack(K2, N2, 1'b0);
        mreq = 1'b0;
        expect_port(5, K2, "R3 second key");
        expect_reg(2'd0, 32'h4, "R3 status valid, seed 0");

        // R11 writes to read-only words
        wr(2'd0, 32'hF);
        expect_reg(2'd0, 32'h4, "R11 status write ignored");
        wr(2'd3, 32'h1234);
        expect_reg(2'd3, 32'h0, "R11 error address write ignored");

        // R6 / R7 parity
        @(negedge clk);
        perr = 1'b1; paddr = 32'h0000_1F04;
        @(negedge clk);
        perr = 1'b0;
        expect_port(2, 1, "R6 alert raised");
        expect_reg(2'd3, 32'h0000_1F04, "R7 first error address");
        expect_port(2, 1, "R6 alert held");
        expect_reg(2'd0, 32'h5, "R6 error bit sticky");
        perr = 1'b1; paddr = 32'h0000_2230;
        @(negedge clk);
        perr = 1'b0;
        expect_reg(2'd3, 32'h0000_2230, "R7 latest error address");

        // R8 lock
        wr(2'd1, 32'h0);
        expect_reg(2'd1, 32'h1, "R8 lock write of 0 ignored");
        wr(2'd1, 32'h1);
        expect_reg(2'd1, 32'h0, "R8 lock cleared");
        wr(2'd2, 32'h1);
        expect_port(1, 0, "R8 control frozen");
        expect_reg(2'd0, 32'h5, "R8 status unchanged when locked");

        // R9 / R10 escalation, after a fresh reset
        do_reset();
        expect_reg(2'd1, 32'h1, "R1 lock after second reset");
        wr(2'd2, 32'h1);
        ack(K1, N1, 1'b1);
        wr(2'd2, 32'h1);
        @(negedge clk);
        esc = 1'b1;
        @(negedge clk);
        esc = 1'b0;
        expect_port(5, DEFK, "R9 key restored to default");
        expect_port(6, 128'(DEFN), "R9 nonce restored to default");
        expect_reg(2'd0, 32'h2, "R9 escalated status");
        ack(K3, N2, 1'b1);
        expect_port(1, 0, "R10 late ack ends request");
        expect_port(5, DEFK, "R10 late key discarded");
        expect_reg(2'd0, 32'h2, "R10 key valid stays 0");
        wr(2'd2, 32'h1);
        mreq = 1'b1;
        expect_port(1, 0, "R9 renewal ignored when escalated");
        expect_port(3, 0, "R9 traffic blocked");
        expect_port(4, 1, "R9 stall when escalated");
        @(negedge clk);
        mreq = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule